// File: doc/BRIEF.md
# Three-Phase Accumulator Processor Core

This block is a small 8-bit stored-program processor that executes a thirteen-instruction subset of 8051 machine code, byte for byte. It keeps programs and operands in one external program memory. That memory is reached through an 8-bit address bus, an 8-bit read-data input and an active-low read strobe. Inside the core are an accumulator, a carry bit, an 8-bit program counter, an instruction register, an operand (auxiliary) register and eight 8-bit working registers. A hardwired controller, driven by the instruction register and the accumulator-zero condition, steers them.

Every instruction occupies three clocks. The first clock captures the opcode and advances the program counter. The second clock collects the operand into the auxiliary register, either as the next program byte or as a working register. The third clock commits the result to the accumulator, to a working register or to the program counter. The accumulator and carry are also driven to output pins so that a program's progress can be followed from outside.

Top module: `tpc_core`

## Requirements
- R1: A synchronous active-high reset sets the program counter, accumulator and carry to zero. On the first clock after release, the core is in its opcode-read cycle with `prog_rd_n` low and `prog_addr` at 0.
- R2: Each instruction lasts exactly three clocks. An instruction that does not branch continues at its opcode address plus 1 if it is one byte long, or plus 2 if it is two bytes long. The program counter wraps modulo 256.
- R3: Immediate forms take the byte after the opcode as the operand. 0x74 loads it into the accumulator. 0x34 adds it to the accumulator together with the carry.
- R4: Register-source forms use opcode bits 2:0 to pick the working register. The encodings are 11101nnn for a copy into the accumulator, 00111nnn for an add with carry, 01011nnn for AND, 01001nnn for OR and 01101nnn for XOR.
- R5: Opcode 11111nnn copies the accumulator into working register nnn. The accumulator, the carry and the other working registers stay unchanged.
- R6: Add-with-carry sets the accumulator to (acc + operand + carry) mod 256 and sets the carry to the ninth bit of that sum. Opcode 0xC3 clears the carry and 0xD3 sets it. No other instruction alters the carry.
- R7: Opcode 0xC4 exchanges the upper and lower nibbles of the accumulator.
- R8: Opcode 0x80 followed by rel always continues at (opcode address + 2 + rel) mod 256, where rel is a two's-complement byte.
- R9: Opcode 0x60 followed by rel goes to the same target as R8 only when the accumulator is zero. Otherwise it continues at opcode address + 2.
- R10: `prog_rd_n` is low in the opcode-read cycle and in the operand cycle of a two-byte instruction, and high in all other cycles. While the strobe is low, `prog_addr` carries the byte address being read.
- R11: Any opcode outside the set above runs as a three-clock no-operation. It leaves the accumulator and carry unchanged and advances the program counter by one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| prog_addr | output | 8 | Program memory byte address |
| prog_data | input | 8 | Program memory read data, valid while the strobe is low |
| prog_rd_n | output | 1 | Program memory read strobe, active low |
| acc_out | output | 8 | Current accumulator value |
| carry_out | output | 1 | Current carry bit |

## Verification
The assertions check the structural timing on every cycle. This covers the fixed fetch, operand and execute rotation, the one-step program counter advance in the opcode and immediate-operand cycles, the strobe staying high in cycles with no read, the accumulator holding outside the execute cycle, a conditional jump being ignored when the accumulator is nonzero, and the reset values. Only the bench's programs can show that the data results are right. These include immediate and register-sourced arithmetic, the carry chain across successive adds, nibble exchange, register write-back observed through later reads, relative targets that wrap past address 0 in both directions, and undefined opcodes falling through. The bench compares these against an instruction-level model at every opcode fetch.

// File: rtl/tpc_pkg.sv
package tpc_pkg;

    localparam int WORD_W = 8;
    localparam int PC_W   = 8;
    localparam int NREGS  = 8;
    localparam int SEL_W  = $clog2(NREGS);

    localparam logic [7:0] OPC_MOV_IMM  = 8'h74;
    localparam logic [7:0] OPC_ADDC_IMM = 8'h34;
    localparam logic [7:0] OPC_SWAP     = 8'hC4;
    localparam logic [7:0] OPC_CLR_C    = 8'hC3;
    localparam logic [7:0] OPC_SET_C    = 8'hD3;
    localparam logic [7:0] OPC_SJMP     = 8'h80;
    localparam logic [7:0] OPC_JZ       = 8'h60;

    localparam logic [4:0] GRP_MOV_A_R  = 5'b11101;
    localparam logic [4:0] GRP_MOV_R_A  = 5'b11111;
    localparam logic [4:0] GRP_ADDC_R   = 5'b00111;
    localparam logic [4:0] GRP_ANL_R    = 5'b01011;
    localparam logic [4:0] GRP_ORL_R    = 5'b01001;
    localparam logic [4:0] GRP_XRL_R    = 5'b01101;

    typedef enum logic [1:0] {
        PH_FETCH  = 2'd0,
        PH_DECODE = 2'd1,
        PH_EXEC   = 2'd2
    } phase_e;

    typedef enum logic [2:0] {
        ALU_PASS = 3'd0,
        ALU_ADDC = 3'd1,
        ALU_AND  = 3'd2,
        ALU_OR   = 3'd3,
        ALU_XOR  = 3'd4,
        ALU_SWAP = 3'd5,
        ALU_CLRC = 3'd6,
        ALU_SETC = 3'd7
    } alu_op_e;

    typedef struct packed {
        alu_op_e alu_op;
        logic    imm;
        logic    reg_src;
        logic    reg_dst;
        logic    acc_we;
        logic    cy_we;
        logic    branch;
        logic    cond_zero;
    } ctrl_t;

    typedef struct packed {
        phase_e              phase;
        logic [PC_W-1:0]     pc;
        logic [WORD_W-1:0]   ir;
        logic [WORD_W-1:0]   aux;
        logic [WORD_W-1:0]   acc;
        logic                cy;
    } core_state_t;

endpackage

// File: rtl/tpc_decode.sv
module tpc_decode
    import tpc_pkg::*;
(
    input  logic [WORD_W-1:0] ir,
    output ctrl_t             ctrl
);

    always_comb begin
        ctrl = '{alu_op: ALU_PASS, imm: 1'b0, reg_src: 1'b0, reg_dst: 1'b0,
                 acc_we: 1'b0, cy_we: 1'b0, branch: 1'b0, cond_zero: 1'b0};
        unique case (ir[7:3])
            GRP_MOV_A_R: begin
                ctrl.reg_src = 1'b1;
                ctrl.acc_we  = 1'b1;
                ctrl.alu_op  = ALU_PASS;
            end
            GRP_MOV_R_A: begin
                ctrl.reg_dst = 1'b1;
            end
            GRP_ADDC_R: begin
                ctrl.reg_src = 1'b1;
                ctrl.acc_we  = 1'b1;
                ctrl.cy_we   = 1'b1;
                ctrl.alu_op  = ALU_ADDC;
            end
            GRP_ANL_R: begin
                ctrl.reg_src = 1'b1;
                ctrl.acc_we  = 1'b1;
                ctrl.alu_op  = ALU_AND;
            end
            GRP_ORL_R: begin
                ctrl.reg_src = 1'b1;
                ctrl.acc_we  = 1'b1;
                ctrl.alu_op  = ALU_OR;
            end
            GRP_XRL_R: begin
                ctrl.reg_src = 1'b1;
                ctrl.acc_we  = 1'b1;
                ctrl.alu_op  = ALU_XOR;
            end
            default: begin
                unique case (ir)
                    OPC_MOV_IMM: begin
                        ctrl.imm    = 1'b1;
                        ctrl.acc_we = 1'b1;
                        ctrl.alu_op = ALU_PASS;
                    end
                    OPC_ADDC_IMM: begin
                        ctrl.imm    = 1'b1;
                        ctrl.acc_we = 1'b1;
                        ctrl.cy_we  = 1'b1;
                        ctrl.alu_op = ALU_ADDC;
                    end
                    OPC_SWAP: begin
                        ctrl.acc_we = 1'b1;
                        ctrl.alu_op = ALU_SWAP;
                    end
                    OPC_CLR_C: begin
                        ctrl.cy_we  = 1'b1;
                        ctrl.alu_op = ALU_CLRC;
                    end
                    OPC_SET_C: begin
                        ctrl.cy_we  = 1'b1;
                        ctrl.alu_op = ALU_SETC;
                    end
                    OPC_SJMP: begin
                        ctrl.imm    = 1'b1;
                        ctrl.branch = 1'b1;
                    end
                    OPC_JZ: begin
                        ctrl.imm       = 1'b1;
                        ctrl.branch    = 1'b1;
                        ctrl.cond_zero = 1'b1;
                    end
                    default: begin
                        ctrl.alu_op = ALU_PASS;
                    end
                endcase
            end
        endcase
    end

endmodule

// File: rtl/tpc_alu.sv
module tpc_alu
    import tpc_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] res,
    output logic         cout
);

    localparam int HALF = W / 2;

    logic [W:0] sum;

    always_comb begin
        sum  = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
        res  = a;
        cout = cin;
        case (op)
            ALU_PASS: res = b;
            ALU_ADDC: begin
                res  = sum[W-1:0];
                cout = sum[W];
            end
            ALU_AND:  res = a & b;
            ALU_OR:   res = a | b;
            ALU_XOR:  res = a ^ b;
            ALU_SWAP: res = {a[HALF-1:0], a[W-1:HALF]};
            ALU_CLRC: cout = 1'b0;
            ALU_SETC: cout = 1'b1;
            default:  res = a;
        endcase
    end

endmodule

// File: rtl/tpc_pc_alu.sv
module tpc_pc_alu
    import tpc_pkg::*;
#(
    parameter int AW = PC_W,
    parameter int DW = WORD_W
) (
    input  logic [AW-1:0] pc,
    input  logic [DW-1:0] rel,
    output logic [AW-1:0] pc_inc,
    output logic [AW-1:0] pc_rel
);

    always_comb begin
        pc_inc = pc + AW'(1);
        pc_rel = pc + AW'($signed(rel));
    end

endmodule

// File: rtl/tpc_regfile.sv
module tpc_regfile
    import tpc_pkg::*;
#(
    parameter int W = WORD_W,
    parameter int N = NREGS
) (
    input  logic                 clk,
    input  logic                 we,
    input  logic [$clog2(N)-1:0] sel,
    input  logic [W-1:0]         wdata,
    output logic [W-1:0]         rdata
);

    localparam int SW = $clog2(N);

    logic [W-1:0] store_q [N];

    for (genvar g = 0; g < N; g++) begin : g_entry
        logic hit;
        assign hit = we && (sel == SW'(g));
        always_ff @(posedge clk) begin
            if (hit) begin
                store_q[g] <= wdata;
            end
        end
    end

    assign rdata = store_q[sel];

endmodule

// File: rtl/tpc_core.sv
module tpc_core
    import tpc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    output logic [PC_W-1:0]   prog_addr,
    input  logic [WORD_W-1:0] prog_data,
    output logic              prog_rd_n,
    output logic [WORD_W-1:0] acc_out,
    output logic              carry_out
);

    core_state_t cur_q, nxt_d;
    ctrl_t       ctrl;

    logic [WORD_W-1:0] alu_res;
    logic              alu_cout;
    logic [PC_W-1:0]   pc_inc, pc_rel;
    logic [WORD_W-1:0] rf_rdata;
    logic              rf_we_d;
    logic              rd_n_d;
    logic              acc_zero;
    logic              take_branch;

    tpc_decode u_dec (
        .ir   (cur_q.ir),
        .ctrl (ctrl)
    );

    tpc_alu #(.W(WORD_W)) u_alu (
        .op   (ctrl.alu_op),
        .a    (cur_q.acc),
        .b    (cur_q.aux),
        .cin  (cur_q.cy),
        .res  (alu_res),
        .cout (alu_cout)
    );

    tpc_pc_alu #(.AW(PC_W), .DW(WORD_W)) u_pca (
        .pc     (cur_q.pc),
        .rel    (cur_q.aux),
        .pc_inc (pc_inc),
        .pc_rel (pc_rel)
    );

    tpc_regfile #(.W(WORD_W), .N(NREGS)) u_rf (
        .clk   (clk),
        .we    (rf_we_d),
        .sel   (cur_q.ir[SEL_W-1:0]),
        .wdata (cur_q.acc),
        .rdata (rf_rdata)
    );

    assign acc_zero    = (cur_q.acc == '0);
    assign take_branch = ctrl.branch && (!ctrl.cond_zero || acc_zero);

    always_comb begin
        nxt_d   = cur_q;
        rd_n_d  = 1'b1;
        rf_we_d = 1'b0;
        unique case (cur_q.phase)
            PH_FETCH: begin
                rd_n_d      = 1'b0;
                nxt_d.ir    = prog_data;
                nxt_d.pc    = pc_inc;
                nxt_d.phase = PH_DECODE;
            end
            PH_DECODE: begin
                if (ctrl.imm) begin
                    rd_n_d    = 1'b0;
                    nxt_d.aux = prog_data;
                    nxt_d.pc  = pc_inc;
                end else if (ctrl.reg_src) begin
                    nxt_d.aux = rf_rdata;
                end
                nxt_d.phase = PH_EXEC;
            end
            PH_EXEC: begin
                if (take_branch) begin
                    nxt_d.pc = pc_rel;
                end
                if (ctrl.reg_dst) begin
                    rf_we_d = 1'b1;
                end
                if (ctrl.acc_we) begin
                    nxt_d.acc = alu_res;
                end
                if (ctrl.cy_we) begin
                    nxt_d.cy = alu_cout;
                end
                nxt_d.phase = PH_FETCH;
            end
            default: begin
                nxt_d.phase = PH_FETCH;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '{phase: PH_FETCH, pc: '0, ir: '0, aux: '0, acc: '0, cy: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign prog_addr = cur_q.pc;
    assign prog_rd_n = rd_n_d;
    assign acc_out   = cur_q.acc;
    assign carry_out = cur_q.cy;

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cur_q.pc == '0 && cur_q.acc == '0 && !cur_q.cy
                        && cur_q.phase == PH_FETCH));

    // R2
    fetch_to_decode_chk: assert property (@(posedge clk) disable iff (rst)
        cur_q.phase == PH_FETCH |=> cur_q.phase == PH_DECODE);

    // R2
    decode_to_exec_chk: assert property (@(posedge clk) disable iff (rst)
        cur_q.phase == PH_DECODE |=> cur_q.phase == PH_EXEC);

    // R2
    exec_to_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        cur_q.phase == PH_EXEC |=> cur_q.phase == PH_FETCH);

    // R2
    fetch_pc_step_chk: assert property (@(posedge clk) disable iff (rst)
        cur_q.phase == PH_FETCH |=> cur_q.pc == $past(cur_q.pc) + PC_W'(1));

    // R2
    operand_pc_step_chk: assert property (@(posedge clk) disable iff (rst)
        (cur_q.phase == PH_DECODE && ctrl.imm) |=> cur_q.pc == $past(cur_q.pc) + PC_W'(1));

    // R10
    idle_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (cur_q.phase == PH_EXEC || (cur_q.phase == PH_DECODE && !ctrl.imm)) |-> prog_rd_n);

    // R5
    acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        cur_q.phase != PH_EXEC |=> $stable(cur_q.acc));

    // R9
    jz_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (cur_q.phase == PH_EXEC && ctrl.cond_zero && cur_q.acc != '0)
            |=> cur_q.pc == $past(cur_q.pc));

endmodule

// File: tb/sim_tpc_core.sv
`timescale 1ns/1ps
module sim_tpc_core;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] prog_addr;
    logic [7:0] prog_data;
    logic       prog_rd_n;
    logic [7:0] acc_out;
    logic       carry_out;

    logic [7:0] mem [256];

    always #2 clk = ~clk;

    assign prog_data = mem[prog_addr];

    tpc_core u0 (
        .clk       (clk),
        .rst       (rst),
        .prog_addr (prog_addr),
        .prog_data (prog_data),
        .prog_rd_n (prog_rd_n),
        .acc_out   (acc_out),
        .carry_out (carry_out)
    );

    typedef struct packed {
        logic [7:0] pc;
        logic [7:0] acc;
        logic       cy;
        logic       two;
    } exp_t;

    exp_t  exp_q [$];
    string tag_q [$];

    int n_checks = 0;
    int n_fail   = 0;
    int wp       = 0;

    logic [7:0] m_pc, m_acc;
    logic       m_cy;
    logic [7:0] m_rf [8];

    task automatic chk(string tag, string what, int act, int expv);
        n_checks++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, expv);
        end
    endtask

    function automatic logic is_two(logic [7:0] op);
        return (op == 8'h74) || (op == 8'h34) || (op == 8'h80) || (op == 8'h60);
    endfunction

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        wp = 0;
    endtask

    task automatic emit(logic [7:0] v);
        mem[wp[7:0]] = v;
        wp++;
    endtask

    // instruction-level model built from the requirements
    task automatic model_step(output string t);
        logic [7:0] op, b1;
        logic [2:0] n;
        logic [8:0] s;
        op = mem[m_pc];
        b1 = mem[m_pc + 8'd1];
        n  = op[2:0];
        if (op == 8'h74) begin
            m_acc = b1; m_pc = m_pc + 8'd2; t = "R3";
        end else if (op == 8'h34) begin
            s = {1'b0, m_acc} + {1'b0, b1} + {8'd0, m_cy};
            m_acc = s[7:0]; m_cy = s[8]; m_pc = m_pc + 8'd2; t = "R3 R6";
        end else if (op[7:3] == 5'b11101) begin
            m_acc = m_rf[n]; m_pc = m_pc + 8'd1; t = "R4";
        end else if (op[7:3] == 5'b11111) begin
            m_rf[n] = m_acc; m_pc = m_pc + 8'd1; t = "R5";
        end else if (op[7:3] == 5'b00111) begin
            s = {1'b0, m_acc} + {1'b0, m_rf[n]} + {8'd0, m_cy};
            m_acc = s[7:0]; m_cy = s[8]; m_pc = m_pc + 8'd1; t = "R4 R6";
        end else if (op[7:3] == 5'b01011) begin
            m_acc = m_acc & m_rf[n]; m_pc = m_pc + 8'd1; t = "R4";
        end else if (op[7:3] == 5'b01001) begin
            m_acc = m_acc | m_rf[n]; m_pc = m_pc + 8'd1; t = "R4";
        end else if (op[7:3] == 5'b01101) begin
            m_acc = m_acc ^ m_rf[n]; m_pc = m_pc + 8'd1; t = "R4";
        end else if (op == 8'hC4) begin
            m_acc = {m_acc[3:0], m_acc[7:4]}; m_pc = m_pc + 8'd1; t = "R7";
        end else if (op == 8'hC3) begin
            m_cy = 1'b0; m_pc = m_pc + 8'd1; t = "R6";
        end else if (op == 8'hD3) begin
            m_cy = 1'b1; m_pc = m_pc + 8'd1; t = "R6";
        end else if (op == 8'h80) begin
            m_pc = m_pc + 8'd2 + b1; t = "R8";
        end else if (op == 8'h60) begin
            if (m_acc == 8'd0) m_pc = m_pc + 8'd2 + b1;
            else               m_pc = m_pc + 8'd2;
            t = "R9";
        end else begin
            m_pc = m_pc + 8'd1; t = "R11";
        end
    endtask

    // driver: reset the core, push the expected state at every opcode fetch
    task automatic run_prog(int n);
        string t;
        @(posedge clk); #1 rst = 1'b1;
        repeat (2) @(posedge clk);
        m_pc = 8'd0; m_acc = 8'd0; m_cy = 1'b0;
        t = "R1";
        for (int k = 0; k <= n; k++) begin
            exp_q.push_back('{pc: m_pc, acc: m_acc, cy: m_cy, two: is_two(mem[m_pc])});
            tag_q.push_back(t);
            if (k < n) model_step(t);
        end
        @(posedge clk); #1 rst = 1'b0;
        while (exp_q.size() != 0) @(posedge clk);
        repeat (4) @(posedge clk);
    endtask

    // monitor: the slot counter follows the fixed three-clock rhythm (R2)
    int    slot = 0;
    bit    live = 1'b0;
    exp_t  cur;
    string ctag;

    always @(negedge clk) begin
        if (rst) begin
            slot = 0;
            live = 1'b0;
        end else begin
            case (slot)
                0: begin
                    if (exp_q.size() != 0) begin
                        cur  = exp_q.pop_front();
                        ctag = tag_q.pop_front();
                        live = 1'b1;
                        chk({ctag, " R2"}, "fetch address", int'(prog_addr), int'(cur.pc));
                        chk(ctag, "accumulator", int'(acc_out), int'(cur.acc));
                        chk(ctag, "carry", int'(carry_out), int'(cur.cy));
                        chk("R10", "strobe in opcode read", int'(prog_rd_n), 0);
                    end else begin
                        live = 1'b0;
                    end
                end
                1: begin
                    if (live) begin
                        chk("R10", "strobe in operand cycle", int'(prog_rd_n), int'(!cur.two));
                        if (cur.two)
                            chk("R10 R3", "operand address", int'(prog_addr), int'(cur.pc + 8'd1));
                    end
                end
                default: begin
                    if (live) chk("R10", "strobe in execute", int'(prog_rd_n), 1);
                end
            endcase
            slot = (slot == 2) ? 0 : slot + 1;
        end
    end

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL R2 watchdog act=running exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        // R3 R4 R5 R7 R11: loads, register logic ops, nibble swap, unknown opcodes
        clear_mem();
        emit(8'h74); emit(8'h5A); emit(8'hF9); emit(8'h74); emit(8'h0F);
        emit(8'hFA); emit(8'hC4); emit(8'h49); emit(8'h5A); emit(8'h69);
        emit(8'hE9); emit(8'hEA); emit(8'h00); emit(8'hA5);
        run_prog(12);

        // R6: carry set/clear and carry propagation through add-with-carry
        clear_mem();
        emit(8'hD3); emit(8'h74); emit(8'hFF); emit(8'h34); emit(8'h01);
        emit(8'h34); emit(8'h10); emit(8'hC3); emit(8'hF8); emit(8'h74);
        emit(8'hF0); emit(8'h38); emit(8'hC3); emit(8'h00);
        run_prog(10);

        // R8 R9: conditional jump taken and not taken, jump-to-self loop
        clear_mem();
        emit(8'h74); emit(8'h00); emit(8'h60); emit(8'h03);
        emit(8'h74); emit(8'hAA); emit(8'h00);
        emit(8'h74); emit(8'h01); emit(8'h60); emit(8'h05);
        emit(8'h80); emit(8'hFE);
        run_prog(7);

        // R8 R9 R2: targets wrapping past 0 both ways, counter wrap 255 -> 0
        clear_mem();
        emit(8'h80); emit(8'h80);
        wp = 130; emit(8'h80); emit(8'h7F);
        wp = 3;
        emit(8'h74); emit(8'h33); emit(8'hC4); emit(8'hF8); emit(8'hE8);
        emit(8'h74); emit(8'h00); emit(8'h60); emit(8'hF0);
        run_prog(12);

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule